// File: doc/BRIEF.md
# Serial-Loaded Dual Wiper Register

This block holds the two 8-bit wiper codes of a two-channel digitally controlled resistor and loads them over a serial link. While chip select is low, each rising edge of the serial clock pushes one bit into a 9-bit shift register. When chip select returns high, the top bit of that register chooses a channel and the eight bits below it become that channel's new wiper code. The channel that is not chosen keeps its code.

The far end of the shift register drives the serial output, so several such blocks can share one chip select and be loaded as a chain. An active-low preset forces both codes to midscale (0x80) at any time, and both codes also start at 0x80 after reset. An active-low sleep input is passed to one flag per channel, for the analog side to open its A terminal. It leaves the stored codes alone.

The serial inputs are sampled by the block clock `clk`, which must run at least four times faster than the serial clock. They are treated as synchronous to `clk`.

Top module: `wiper_pair_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both wiper codes read 0x80 and `sdo` reads 0.
- R2: A frame is sent address bit first, followed by data bits 7 down to 0. Each bit is taken from `sdi` on a rising edge of `sclk` that occurs while `cs_n` is low.
- R3: On a rising edge of `cs_n`, address bit 0 writes the eight data bits to `tap0`, and `tap1` keeps its value.
- R4: On a rising edge of `cs_n`, address bit 1 writes the eight data bits to `tap1`, and `tap0` keeps its value.
- R5: A wiper code changes only on a rising edge of `cs_n` or through preset or reset. Shifting alone never alters it.
- R6: `sdo` presents the most significant bit of the 9-bit shift register. A frame shifted into one block therefore appears on its `sdo` nine serial clocks later, first bit first.
- R7: Rising edges of `sclk` while `cs_n` is high leave the shift register unchanged. This can be seen on `sdo` and in the code that the next commit writes.
- R8: A frame of any length other than nine clocks commits whatever the register then holds: the latest bit shifted in is data bit 0, and the bit eight places above it is the address.
- R9: While `preset_n` is low, both codes read 0x80 without waiting for a clock edge, and a commit in that time is lost. Preset does not alter the shift register.
- R10: `sleep0_n` and `sleep1_n` follow `sleep_n`, and a change of `sleep_n` leaves both wiper codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Active-low chip select; its rising edge commits the frame |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out from the far end of the shift register |
| preset_n | input | 1 | Asynchronous active-low preset of both codes to midscale |
| sleep_n | input | 1 | Active-low sleep request for both channels |
| tap0 | output | DW | Wiper code of channel 0 (address 0) |
| tap1 | output | DW | Wiper code of channel 1 (address 1) |
| sleep0_n | output | 1 | Active-low sleep flag of channel 0 |
| sleep1_n | output | 1 | Active-low sleep flag of channel 1 |

## Verification
The shift register can only be seen through `sdo` and through the next commit. Two behaviours are therefore the hardest to show: that preset leaves the register alone, and that clocks outside chip select are ignored. The bench handles both the same way. After the event under test, it drops and raises chip select with no serial clocks in between. That commit writes back exactly what the register still holds, and a changed register would send a different code to a different channel. Short and long frames are built the same way, on top of a known earlier frame, so that the expected address and data can be worked out by hand.

// File: rtl/wiper_pair_ctrl.sv
module wiper_pair_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  input  logic          preset_n,
  input  logic          sleep_n,
  output logic [DW-1:0] tap0,
  output logic [DW-1:0] tap1,
  output logic          sleep0_n,
  output logic          sleep1_n
);
  localparam int FW = DW + 1;
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic          sclk_q;
  logic          cs_q;
  logic [FW-1:0] frame_q;

  wire shift_en = !cs_n && sclk && !sclk_q;
  wire commit   = cs_n && !cs_q;
  wire hold_clr_n = rst_n & preset_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      frame_q <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (shift_en) frame_q <= {frame_q[FW-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge hold_clr_n) begin
    if (!hold_clr_n) begin
      tap0 <= MID;
      tap1 <= MID;
    end else if (commit) begin
      if (frame_q[FW-1]) tap1 <= frame_q[DW-1:0];
      else               tap0 <= frame_q[DW-1:0];
    end
  end

  assign sdo      = frame_q[FW-1];
  assign sleep0_n = sleep_n;
  assign sleep1_n = sleep_n;
endmodule

// File: rtl/wiper_pair_ctrl_chk.sv
module wiper_pair_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          preset_n,
  input logic          sdo,
  input logic [DW-1:0] tap0,
  input logic [DW-1:0] tap1
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  assert_one_channel_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_n && $past(preset_n)) |-> ($stable(tap0) || $stable(tap1)));

  assert_change_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_n && $past(preset_n) && (!$stable(tap0) || !$stable(tap1)))
      |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_idle_sdo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> $stable(sdo));

  assert_preset_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |-> (tap0 == MID && tap1 == MID));
endmodule

bind wiper_pair_ctrl wiper_pair_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .preset_n(preset_n),
  .sdo(sdo), .tap0(tap0), .tap1(tap1)
);

// File: tb/wiper_pair_ctrl_bench.sv
module wiper_pair_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic preset_n = 1'b1, sleep_n = 1'b1;
  logic sdo, sleep0_n, sleep1_n;
  logic [7:0] tap0, tap1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wiper_pair_ctrl u_wiper_pair_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .preset_n(preset_n), .sleep_n(sleep_n), .tap0(tap0), .tap1(tap1),
    .sleep0_n(sleep0_n), .sleep1_n(sleep1_n)
  );

  // {addr, data, expected tap0, expected tap1}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'h3C, 8'h3C, 8'h80},
    {1'b1, 8'hA5, 8'h3C, 8'hA5},
    {1'b0, 8'hFF, 8'hFF, 8'hA5},
    {1'b1, 8'h00, 8'hFF, 8'h00},
    {1'b0, 8'h01, 8'h01, 8'h00},
    {1'b1, 8'h80, 8'h01, 8'h80}
  };

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic taps(input string req, input logic [7:0] e0, input logic [7:0] e1);
    chk(tap0 == e0, req, {1'b0, tap0}, {1'b0, e0});
    chk(tap1 == e1, req, {1'b0, tap1}, {1'b0, e1});
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b0;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic frame(input logic [11:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(bits[i]);
  endtask

  task automatic select; @(negedge clk); cs_n = 1'b0; @(negedge clk); endtask
  task automatic release_cs; @(negedge clk); cs_n = 1'b1; repeat (2) @(negedge clk); endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] p0, p1;
    logic [8:0] f1, f2;
    repeat (3) @(negedge clk);
    taps("R1 in reset", 8'h80, 8'h80);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    taps("R1 after reset", 8'h80, 8'h80);
    chk(sdo == 1'b0, "R1 sdo", {8'd0, sdo}, 9'd0);

    p0 = 8'h80; p1 = 8'h80;
    for (int v = 0; v < 6; v++) begin
      select();
      frame({3'b0, VEC[v][24:16]}, 9);
      taps("R5 before commit", p0, p1);
      release_cs();
      taps(VEC[v][24] ? "R4 R2 load ch1" : "R3 R2 load ch0", VEC[v][15:8], VEC[v][7:0]);
      p0 = VEC[v][15:8]; p1 = VEC[v][7:0];
    end

    f1 = 9'h0C3; f2 = 9'h13C;
    select();
    frame({3'b0, f1}, 9);
    for (int j = 0; j < 9; j++) begin
      chk(sdo == f1[8-j], "R6 chained bit", {8'd0, sdo}, {8'd0, f1[8-j]});
      bit_out(f2[8-j]);
    end
    chk(sdo == f2[8], "R6 next frame head", {8'd0, sdo}, {8'd0, f2[8]});
    release_cs();
    taps("R4 after chain", 8'h01, 8'h3C);

    select(); frame({3'b0, 9'h05A}, 9); release_cs();
    taps("R3 setup", 8'h5A, 8'h3C);
    for (int k = 0; k < 4; k++) bit_out(1'b1);
    chk(sdo == 1'b0, "R7 idle clocks sdo", {8'd0, sdo}, 9'd0);
    select(); release_cs();
    taps("R7 idle clocks ignored", 8'h5A, 8'h3C);

    select(); frame(12'hF69 | 12'h100, 12); release_cs();
    taps("R8 long frame", 8'h5A, 8'h69);
    select(); frame(12'h015, 5); release_cs();
    taps("R8 short frame", 8'h5A, 8'h35);

    @(negedge clk); preset_n = 1'b0; #1;
    taps("R9 async preset", 8'h80, 8'h80);
    select(); frame({3'b0, 9'h011}, 9); release_cs();
    taps("R9 commit during preset", 8'h80, 8'h80);
    @(negedge clk); preset_n = 1'b1; repeat (2) @(negedge clk);
    taps("R9 after release", 8'h80, 8'h80);
    select(); release_cs();
    taps("R9 register kept", 8'h11, 8'h80);

    @(negedge clk); sleep_n = 1'b0; @(negedge clk);
    chk(!sleep0_n && !sleep1_n, "R10 sleep on", {7'd0, sleep1_n, sleep0_n}, 9'd0);
    taps("R10 codes kept", 8'h11, 8'h80);
    sleep_n = 1'b1; @(negedge clk);
    chk(sleep0_n && sleep1_n, "R10 sleep off", {7'd0, sleep1_n, sleep0_n}, 9'd3);
    taps("R10 codes kept after", 8'h11, 8'h80);

    done = 1'b1;
    finish_run();
  end
endmodule